// File: doc/BRIEF.md
# Radix-4 Flat-Comparator Compare-Select and Traceback Pair

This block holds the two halves of a radix-4 state-metric recursion step that keeps storage small. The forward half takes four candidate path metrics, called A, B, C and D. It compares every pair of them at once and returns the winning metric together with a two-bit winner index. It also returns three differences, each taken with candidate A as the reference. The index and the differences are what a metric cache would keep in place of four full metrics.

The traceback half takes a stored record, made of the winning metric, the index and the three differences, and rebuilds all four candidates exactly. It first recovers A from the winner and the index. It then recovers B, C and D by subtracting each difference from A.

Both halves are one-stage pipelines with valid/ready streams. A word moves on a clock edge where valid and ready are both high. An output word that is not taken stays exactly as it is. An upstream stage may accept a new word when its output register is empty, or when that register is being emptied in the same cycle. A compile-time switch adds a small correction term to the winning metric, which turns max-log behaviour into log-MAP behaviour. The traceback half removes the same term before it rebuilds A, so the rebuild stays exact in both modes.

Top module: `r4tb_pair`

## Requirements
- R1: Each accepted forward word produces `fw_out_max` equal to the largest of the four candidates, under signed comparison, plus the correction of R4, taken modulo 2^W.
- R2: `fw_out_sel` names the winner with the encoding 0 = A, 1 = B, 2 = C, 3 = D. When candidates tie for the largest value, the lowest of those codes is chosen.
- R3: `fw_out_dab`, `fw_out_dac` and `fw_out_dad` equal A−B, A−C and A−D, each taken modulo 2^W.
- R4: When CORR_EN is 1, the correction is 2 if the gap between the winner and the best of the other three candidates is 0 or 1. It is 1 if that gap is 2 or 3, and 0 if the gap is larger. When CORR_EN is 0, the correction is always 0.
- R5: A traceback word built from the forward outputs of the same candidates makes `tb_out_a` to `tb_out_d` equal to the original A to D. This holds for every winner index, including the index 0, where A is the corrected-back maximum itself.
- R6: On both streams, a word is accepted on an edge where valid and ready are high, and its result is valid one cycle later. `*_in_ready` equals the inverse of out-valid OR'd with out-ready. While out-valid is high and out-ready is low, every output stays unchanged and no new input is taken.
- R7: While `rst_n` is low, and after it is released, both out-valid signals are low and both in-ready signals are high until a word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fw_in_valid | input | 1 | Forward input word valid |
| fw_in_ready | output | 1 | Forward stage can take a word |
| fw_in_a | input | W | Candidate A, signed |
| fw_in_b | input | W | Candidate B, signed |
| fw_in_c | input | W | Candidate C, signed |
| fw_in_d | input | W | Candidate D, signed |
| fw_out_valid | output | 1 | Forward result valid |
| fw_out_ready | input | 1 | Forward result taken |
| fw_out_max | output | W | Winning metric with correction |
| fw_out_sel | output | 2 | Winner index |
| fw_out_dab | output | W | A−B |
| fw_out_dac | output | W | A−C |
| fw_out_dad | output | W | A−D |
| tb_in_valid | input | 1 | Traceback record valid |
| tb_in_ready | output | 1 | Traceback stage can take a record |
| tb_in_max | input | W | Stored winning metric |
| tb_in_sel | input | 2 | Stored winner index |
| tb_in_dab | input | W | Stored A−B |
| tb_in_dac | input | W | Stored A−C |
| tb_in_dad | input | W | Stored A−D |
| tb_out_valid | output | 1 | Rebuilt metrics valid |
| tb_out_ready | input | 1 | Rebuilt metrics taken |
| tb_out_a | output | W | Rebuilt A |
| tb_out_b | output | W | Rebuilt B |
| tb_out_c | output | W | Rebuilt C |
| tb_out_d | output | W | Rebuilt D |

## Verification
The assertions assume that the four candidates of any forward word lie within 2^(W-1)−1 of one another, as normalized state metrics do. Under that bound the stored differences keep their true sign, which the ordering check on the index and the differences relies on. They also assume that traceback records come from this same forward stage. The random stimulus draws a base value and offsets of at most ±120 around it, and the directed corner words stay at or below the spread limit, so the bound holds for every word. Traceback inputs are always built from the bench's own model of the forward result.

// File: rtl/r4tb_pkg.sv
package r4tb_pkg;
  localparam int NCAND = 4;
  localparam int SELW  = 2;
  // correction tiers on the gap between winner and runner-up
  localparam int CORR_GAP_NEAR = 1;
  localparam int CORR_GAP_MID  = 3;
  localparam int CORR_VAL_NEAR = 2;
  localparam int CORR_VAL_MID  = 1;

  typedef enum logic [SELW-1:0] {PICK_A = 2'd0, PICK_B = 2'd1, PICK_C = 2'd2, PICK_D = 2'd3} pick_e;
endpackage

// File: rtl/r4tb_flat_cmp.sv
module r4tb_flat_cmp
  import r4tb_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] cand [NCAND],
  output logic [SELW-1:0]     sel
);
  // ge[i][j], i<j: candidate i is not below candidate j
  logic [NCAND-1:0][NCAND-1:0] ge;
  logic [NCAND-1:0]            wins;
  logic signed [W:0]           pdiff;

  always_comb begin
    ge    = '0;
    pdiff = '0;
    for (int i = 0; i < NCAND; i++) begin
      for (int j = i + 1; j < NCAND; j++) begin
        pdiff    = {cand[i][W-1], cand[i]} - {cand[j][W-1], cand[j]};
        ge[i][j] = ~pdiff[W];
      end
    end
  end

  // candidate k wins if it beats every lower index strictly and ties or beats every higher one
  always_comb begin
    for (int k = 0; k < NCAND; k++) begin
      wins[k] = 1'b1;
      for (int j = 0; j < NCAND; j++) begin
        if (j > k && !ge[k][j]) wins[k] = 1'b0;
        if (j < k && ge[j][k])  wins[k] = 1'b0;
      end
    end
  end

  assign sel = {wins[2] | wins[3], wins[1] | wins[3]};

  assert_single_winner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wins) == 1);
endmodule

// File: rtl/r4tb_corr.sv
module r4tb_corr
  import r4tb_pkg::*;
#(
  parameter int W       = 10,
  parameter bit CORR_EN = 1'b1
) (
  input  logic signed [W-1:0] rel_b,
  input  logic signed [W-1:0] rel_c,
  input  logic signed [W-1:0] rel_d,
  input  logic [SELW-1:0]     sel,
  output logic [W-1:0]        corr
);
  generate
    if (CORR_EN) begin : g_logmap
      logic signed [W:0] rel [NCAND];
      logic signed [W:0] best;
      logic              have;
      logic [W:0]        gap;

      always_comb begin
        rel[0] = '0;
        rel[1] = {rel_b[W-1], rel_b};
        rel[2] = {rel_c[W-1], rel_c};
        rel[3] = {rel_d[W-1], rel_d};
        best   = '0;
        have   = 1'b0;
        for (int k = 0; k < NCAND; k++) begin
          if (k != int'(sel) && (!have || rel[k] > best)) begin
            best = rel[k];
            have = 1'b1;
          end
        end
        gap = rel[sel] - best;
        if (gap <= (W+1)'(CORR_GAP_NEAR))     corr = W'(CORR_VAL_NEAR);
        else if (gap <= (W+1)'(CORR_GAP_MID)) corr = W'(CORR_VAL_MID);
        else                                  corr = '0;
      end
    end else begin : g_maxlog
      assign corr = '0;
    end
  endgenerate
endmodule

// File: rtl/r4tb_fwd_stage.sv
module r4tb_fwd_stage
  import r4tb_pkg::*;
#(
  parameter int W       = 10,
  parameter bit CORR_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_a,
  input  logic signed [W-1:0] in_b,
  input  logic signed [W-1:0] in_c,
  input  logic signed [W-1:0] in_d,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_max,
  output logic [SELW-1:0]     out_sel,
  output logic signed [W-1:0] out_dab,
  output logic signed [W-1:0] out_dac,
  output logic signed [W-1:0] out_dad
);
  logic signed [W-1:0] cand [NCAND];
  logic [SELW-1:0]     sel;
  logic signed [W-1:0] dab, dac, dad, win, max_n;
  logic [W-1:0]        corr;

  assign cand[0] = in_a;
  assign cand[1] = in_b;
  assign cand[2] = in_c;
  assign cand[3] = in_d;

  r4tb_flat_cmp #(.W(W)) u_cmp (.clk(clk), .rst_n(rst_n), .cand(cand), .sel(sel));

  assign dab = in_a - in_b;
  assign dac = in_a - in_c;
  assign dad = in_a - in_d;
  assign win = cand[sel];

  r4tb_corr #(.W(W), .CORR_EN(CORR_EN)) u_corr (
    .rel_b(-dab), .rel_c(-dac), .rel_d(-dad), .sel(sel), .corr(corr));

  assign max_n    = win + $signed(corr);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
    if (in_valid && in_ready) begin
      out_max <= max_n;
      out_sel <= sel;
      out_dab <= dab;
      out_dac <= dac;
      out_dad <= dad;
    end
  end

  assert_fw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_max, out_sel, out_dab, out_dac, out_dad}));

  // relies on bounded candidate spread so that stored differences keep their sign
  assert_fw_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |->
      (out_sel == PICK_A ? (out_dab >= 0 && out_dac >= 0 && out_dad >= 0) :
       out_sel == PICK_B ? (out_dab < 0 && out_dab <= out_dac && out_dab <= out_dad) :
       out_sel == PICK_C ? (out_dac < 0 && out_dac < out_dab && out_dac <= out_dad) :
                           (out_dad < 0 && out_dad < out_dab && out_dad < out_dac)));

  assert_fw_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/r4tb_trace_stage.sv
module r4tb_trace_stage
  import r4tb_pkg::*;
#(
  parameter int W       = 10,
  parameter bit CORR_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_max,
  input  logic [SELW-1:0]     in_sel,
  input  logic signed [W-1:0] in_dab,
  input  logic signed [W-1:0] in_dac,
  input  logic signed [W-1:0] in_dad,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_a,
  output logic signed [W-1:0] out_b,
  output logic signed [W-1:0] out_c,
  output logic signed [W-1:0] out_d
);
  logic [W-1:0]        corr;
  logic signed [W-1:0] raw, d_sel, a_rec;

  r4tb_corr #(.W(W), .CORR_EN(CORR_EN)) u_corr (
    .rel_b(-in_dab), .rel_c(-in_dac), .rel_d(-in_dad), .sel(in_sel), .corr(corr));

  assign raw = in_max - $signed(corr);

  always_comb begin
    unique case (in_sel)
      PICK_A:  d_sel = '0;
      PICK_B:  d_sel = in_dab;
      PICK_C:  d_sel = in_dac;
      default: d_sel = in_dad;
    endcase
  end

  // A = winner + (A - winner); the others follow from A
  assign a_rec    = raw + d_sel;
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
    if (in_valid && in_ready) begin
      out_a <= a_rec;
      out_b <= a_rec - in_dab;
      out_c <= a_rec - in_dac;
      out_d <= a_rec - in_dad;
    end
  end

  assert_tb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_a, out_b, out_c, out_d}));

  assert_tb_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_tb_nodrop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: rtl/r4tb_pair.sv
module r4tb_pair
  import r4tb_pkg::*;
#(
  parameter int W       = 10,
  parameter bit CORR_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fw_in_valid,
  output logic                fw_in_ready,
  input  logic signed [W-1:0] fw_in_a,
  input  logic signed [W-1:0] fw_in_b,
  input  logic signed [W-1:0] fw_in_c,
  input  logic signed [W-1:0] fw_in_d,
  output logic                fw_out_valid,
  input  logic                fw_out_ready,
  output logic signed [W-1:0] fw_out_max,
  output logic [1:0]          fw_out_sel,
  output logic signed [W-1:0] fw_out_dab,
  output logic signed [W-1:0] fw_out_dac,
  output logic signed [W-1:0] fw_out_dad,
  input  logic                tb_in_valid,
  output logic                tb_in_ready,
  input  logic signed [W-1:0] tb_in_max,
  input  logic [1:0]          tb_in_sel,
  input  logic signed [W-1:0] tb_in_dab,
  input  logic signed [W-1:0] tb_in_dac,
  input  logic signed [W-1:0] tb_in_dad,
  output logic                tb_out_valid,
  input  logic                tb_out_ready,
  output logic signed [W-1:0] tb_out_a,
  output logic signed [W-1:0] tb_out_b,
  output logic signed [W-1:0] tb_out_c,
  output logic signed [W-1:0] tb_out_d
);
  r4tb_fwd_stage #(.W(W), .CORR_EN(CORR_EN)) u_fwd (
    .clk(clk), .rst_n(rst_n),
    .in_valid(fw_in_valid), .in_ready(fw_in_ready),
    .in_a(fw_in_a), .in_b(fw_in_b), .in_c(fw_in_c), .in_d(fw_in_d),
    .out_valid(fw_out_valid), .out_ready(fw_out_ready),
    .out_max(fw_out_max), .out_sel(fw_out_sel),
    .out_dab(fw_out_dab), .out_dac(fw_out_dac), .out_dad(fw_out_dad));

  r4tb_trace_stage #(.W(W), .CORR_EN(CORR_EN)) u_trace (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tb_in_valid), .in_ready(tb_in_ready),
    .in_max(tb_in_max), .in_sel(tb_in_sel),
    .in_dab(tb_in_dab), .in_dac(tb_in_dac), .in_dad(tb_in_dad),
    .out_valid(tb_out_valid), .out_ready(tb_out_ready),
    .out_a(tb_out_a), .out_b(tb_out_b), .out_c(tb_out_c), .out_d(tb_out_d));

  assert_reset_idle_R7: assert property (@(posedge clk)
    !rst_n |=> !fw_out_valid && !tb_out_valid);
endmodule

// File: tb/r4tb_pair_test.sv
module r4tb_pair_test;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                fw_in_valid = 1'b0, fw_out_ready = 1'b1, tb_in_valid = 1'b0, tb_out_ready = 1'b1;
  logic signed [W-1:0] fa = '0, fb = '0, fc = '0, fd = '0;
  logic signed [W-1:0] l_tmax = '0, l_tdab = '0, l_tdac = '0, l_tdad = '0;
  logic [1:0]          l_tsel = '0, m_tsel = '0;
  logic signed [W-1:0] m_tmax = '0, m_tdab = '0, m_tdac = '0, m_tdad = '0;

  logic                l_fir, l_fov, l_tir, l_tov, m_fir, m_fov, m_tir, m_tov;
  logic signed [W-1:0] l_max, l_dab, l_dac, l_dad, l_a, l_b, l_c, l_d;
  logic signed [W-1:0] m_max, m_dab, m_dac, m_dad, m_a, m_b, m_c, m_d;
  logic [1:0]          l_sel, m_sel;

  r4tb_pair #(.W(W), .CORR_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n),
    .fw_in_valid(fw_in_valid), .fw_in_ready(l_fir),
    .fw_in_a(fa), .fw_in_b(fb), .fw_in_c(fc), .fw_in_d(fd),
    .fw_out_valid(l_fov), .fw_out_ready(fw_out_ready),
    .fw_out_max(l_max), .fw_out_sel(l_sel), .fw_out_dab(l_dab), .fw_out_dac(l_dac), .fw_out_dad(l_dad),
    .tb_in_valid(tb_in_valid), .tb_in_ready(l_tir),
    .tb_in_max(l_tmax), .tb_in_sel(l_tsel), .tb_in_dab(l_tdab), .tb_in_dac(l_tdac), .tb_in_dad(l_tdad),
    .tb_out_valid(l_tov), .tb_out_ready(tb_out_ready),
    .tb_out_a(l_a), .tb_out_b(l_b), .tb_out_c(l_c), .tb_out_d(l_d));

  r4tb_pair #(.W(W), .CORR_EN(1'b0)) uut_ml (
    .clk(clk), .rst_n(rst_n),
    .fw_in_valid(fw_in_valid), .fw_in_ready(m_fir),
    .fw_in_a(fa), .fw_in_b(fb), .fw_in_c(fc), .fw_in_d(fd),
    .fw_out_valid(m_fov), .fw_out_ready(fw_out_ready),
    .fw_out_max(m_max), .fw_out_sel(m_sel), .fw_out_dab(m_dab), .fw_out_dac(m_dac), .fw_out_dad(m_dad),
    .tb_in_valid(tb_in_valid), .tb_in_ready(m_tir),
    .tb_in_max(m_tmax), .tb_in_sel(m_tsel), .tb_in_dab(m_tdab), .tb_in_dac(m_tdac), .tb_in_dad(m_tdad),
    .tb_out_valid(m_tov), .tb_out_ready(tb_out_ready),
    .tb_out_a(m_a), .tb_out_b(m_b), .tb_out_c(m_c), .tb_out_d(m_d));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wrapw(input int x);
    logic signed [W-1:0] t;
    t = x[W-1:0];
    return int'(t);
  endfunction

  // winner index: strict greater keeps the lowest index on ties
  function automatic int model_sel(input int a, b, c, d);
    int v[4];
    int best = 0;
    v = '{a, b, c, d};
    for (int k = 1; k < 4; k++) if (v[k] > v[best]) best = k;
    return best;
  endfunction

  function automatic int model_corr(input int a, b, c, d);
    int v[4];
    int s, ru, gap;
    bit have = 0;
    v = '{a, b, c, d};
    s = model_sel(a, b, c, d);
    ru = 0;
    for (int k = 0; k < 4; k++)
      if (k != s && (!have || v[k] > ru)) begin ru = v[k]; have = 1; end
    gap = v[s] - ru;
    if (gap <= 1) return 2;
    if (gap <= 3) return 1;
    return 0;
  endfunction

  task automatic run_vec(input int a, b, c, d);
    int v[4];
    int s, mx, cr;
    v = '{a, b, c, d};
    s  = model_sel(a, b, c, d);
    mx = v[s];
    cr = model_corr(a, b, c, d);
    @(negedge clk);
    fa = a[W-1:0]; fb = b[W-1:0]; fc = c[W-1:0]; fd = d[W-1:0];
    fw_in_valid = 1'b1;
    chk("R6 fw_in_ready", int'(l_fir), 1);
    @(negedge clk);
    fw_in_valid = 1'b0;
    chk("R6 fw_out_valid", int'(l_fov), 1);
    chk("R1 max logmap", int'(l_max), wrapw(mx + cr));
    chk("R4 max maxlog", int'(m_max), wrapw(mx));
    chk("R2 sel", int'(l_sel), s);
    chk("R2 sel maxlog", int'(m_sel), s);
    chk("R3 dab", int'(l_dab), wrapw(a - b));
    chk("R3 dac", int'(l_dac), wrapw(a - c));
    chk("R3 dad", int'(m_dad), wrapw(a - d));
    // traceback records from the bench model
    l_tmax = W'(mx + cr); l_tsel = 2'(s);
    l_tdab = W'(a - b); l_tdac = W'(a - c); l_tdad = W'(a - d);
    m_tmax = W'(mx); m_tsel = 2'(s);
    m_tdab = W'(a - b); m_tdac = W'(a - c); m_tdad = W'(a - d);
    tb_in_valid = 1'b1;
    @(negedge clk);
    tb_in_valid = 1'b0;
    chk("R6 tb_out_valid", int'(l_tov), 1);
    chk("R5 a", int'(l_a), a);
    chk("R5 b", int'(l_b), b);
    chk("R5 c", int'(l_c), c);
    chk("R5 d", int'(l_d), d);
    chk("R5 a maxlog", int'(m_a), a);
    chk("R5 d maxlog", int'(m_d), d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R7 fw_out_valid in reset", int'(l_fov), 0);
    chk("R7 tb_out_valid in reset", int'(l_tov), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 fw_in_ready after reset", int'(l_fir), 1);
    chk("R7 tb_in_ready after reset", int'(m_tir), 1);
    chk("R7 fw_out_valid after reset", int'(m_fov), 0);

    // directed ties and corners
    run_vec(5, 5, 5, 5);         // R2 full tie -> A
    run_vec(1, 7, 7, 3);         // R2 B over C
    run_vec(0, 2, 9, 9);         // R2 C over D
    run_vec(-4, -4, -9, -9);     // R2 A over B
    run_vec(3, 3, 3, 8);         // R2 D, gap 5
    run_vec(10, 8, 0, 0);        // R4 gap 2 -> 1
    run_vec(-20, -19, -30, -40); // R4 gap 1 -> 2
    run_vec(511, 511, 0, 0);     // R1 corrected max wraps
    run_vec(-512, -512, -1, -100);
    run_vec(-1, -2, -3, -4);     // R5 index A

    // back-pressure (R6)
    @(negedge clk);
    fw_out_ready = 1'b0;
    fa = 10'sd40; fb = 10'sd50; fc = 10'sd0; fd = 10'sd0;
    fw_in_valid = 1'b1;
    @(negedge clk);
    chk("R6 held valid", int'(l_fov), 1);
    chk("R6 ready low when full", int'(l_fir), 0);
    fa = 10'sd90; fb = 10'sd1; fc = 10'sd2; fd = 10'sd3;
    repeat (2) @(negedge clk);
    chk("R6 held max", int'(l_max), 50);
    chk("R6 held sel", int'(l_sel), 1);
    chk("R6 held dab", int'(l_dab), -10);
    fw_out_ready = 1'b1;
    @(negedge clk);
    fw_in_valid = 1'b0;
    chk("R6 next word max", int'(l_max), 90);
    chk("R6 next word sel", int'(l_sel), 0);
    @(negedge clk);
    chk("R6 drained", int'(l_fov), 0);

    // random
    for (int n = 0; n < 400; n++) begin
      int a, b, c, d, sp;
      base = int'($urandom_range(500)) - 250;
      sp = (n % 3 == 0) ? 3 : 120;
      a = base + int'($urandom_range(2 * sp)) - sp;
      b = base + int'($urandom_range(2 * sp)) - sp;
      c = base + int'($urandom_range(2 * sp)) - sp;
      d = base + int'($urandom_range(2 * sp)) - sp;
      run_vec(a, b, c, d);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule